// File: doc/BRIEF.md
# Lossy Last-Value Fast Channel Bank

This block holds an array of word-wide channels between a sender and a receiver. The sender can write any channel at any moment. It never waits and gets no feedback. Each channel keeps only the latest word written to it, and a receiver read returns that word. Every accepted sender write marks the channel pending. The receiver sees a level interrupt that stays high until it clears the pending bit by writing a one to it.

Each channel has a mask bit that keeps its pending state out of the interrupt. A build parameter sets how the interrupt is presented:
- one line per channel, or
- one line per group of consecutive channels, each line the OR of the unmasked pending channels in its group.

A constant configuration word reports the channel count and the word size so that software can discover the layout. Parameters set the number of channels, the word width (32 or 64), the group size and the interrupt variant. Checks at elaboration reject illegal combinations.

Top module: `fastchan_bank`

## Requirements
- R1: After reset every stored word, every pending bit, every mask bit and the read data are zero.
- R2: A sender write to channel i (i < NUM_CH) stores the word. A receiver read of i with rcv_rd_en presents the latest stored word on rcv_rd_data after the next clock edge, and rcv_rd_data then holds that value until the next read.
- R3: A write to a channel that is already pending replaces the word and leaves the pending bit at 1. No other output changes to report it.
- R4: A sender write to channel i sets pend_o[i] at the clock edge that stores the word, and leaves the other pending bits unchanged.
- R5: At a clock edge, each 1 in rcv_clr_vec clears the matching pending bit. A 0 leaves its bit unchanged.
- R6: When a write to channel i and a clear of bit i fall in the same cycle, pend_o[i] is 1 afterwards.
- R7: When a read and a write of the same channel fall in the same cycle, the read returns the newly written word.
- R8: With per-channel interrupts (IRQ_MODE = IRQ_PER_CH), irq_ch[i] equals pend_o[i] AND NOT mask[i] as a level, and irq_grp is all zero.
- R9: With group interrupts (IRQ_MODE = IRQ_PER_GRP), irq_grp[g] is the OR of the unmasked pending bits of channels g*GRP_SIZE through g*GRP_SIZE+GRP_SIZE-1, and irq_ch is all zero.
- R10: rcv_mask_we loads rcv_mask_val into the mask at the clock edge (1 = masked). A masked channel still records pending but drives no interrupt.
- R11: cfg_word[15:0] holds NUM_CH, cfg_word[16] is 1 when WORD_W is 64 and 0 when it is 32, and all other bits are 0.
- R12: A write to an index of NUM_CH or more changes no stored word and no pending bit. A read of such an index returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snd_wr_en | input | 1 | Sender write strobe |
| snd_wr_idx | input | IDX_W | Sender channel index |
| snd_wr_data | input | WORD_W | Sender write word |
| rcv_rd_en | input | 1 | Receiver read strobe |
| rcv_rd_idx | input | IDX_W | Receiver read channel index |
| rcv_rd_data | output | WORD_W | Registered read word |
| rcv_clr_vec | input | NUM_CH | Write-one-to-clear pending vector |
| rcv_mask_we | input | 1 | Mask load strobe |
| rcv_mask_val | input | NUM_CH | New mask value, 1 = masked |
| pend_o | output | NUM_CH | Pending bit per channel |
| irq_ch | output | NUM_CH | Per-channel level interrupts |
| irq_grp | output | NUM_GRP | Per-group level interrupts |
| cfg_word | output | 32 | Channel count and word-size report |

## Verification
Two pairs of functions can fall in the same cycle. A sender write can meet a receiver clear of the same pending bit, and a sender write can meet a receiver read of the same channel. The bench drives each pair in one cycle on purpose. It then requires that the pending bit survives the clear and that the read returns the new word. A random phase also mixes writes, clears, reads and mask loads, so these collisions recur. The behavioural model judges every cycle, for both the per-channel instance and the grouped instance.

// File: rtl/fcb_pkg.sv
package fcb_pkg;
   typedef enum logic {
      IRQ_PER_CH  = 1'b0,
      IRQ_PER_GRP = 1'b1
   } irq_mode_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   function automatic logic [31:0] make_cfg(input int n, input int w);
      logic [31:0] v;
      v        = '0;
      v[15:0]  = 16'(n);
      v[16]    = (w == 64);
      return v;
   endfunction
endpackage

// File: rtl/fcb_store.sv
module fcb_store #(
   parameter int NUM_CH = 6,
   parameter int WORD_W = 32,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] rd_data
);
   logic [NUM_CH-1:0][WORD_W-1:0] mem_q;
   logic                          wr_ok;
   logic                          rd_ok;
   logic [WORD_W-1:0]             rd_next;

   assign wr_ok = wr_en && (int'(wr_idx) < NUM_CH);
   assign rd_ok = int'(rd_idx) < NUM_CH;

   always_comb begin
      rd_next = '0;
      if (rd_ok) begin
         if (wr_ok && (wr_idx == rd_idx)) rd_next = wr_data;
         else                             rd_next = mem_q[rd_idx];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_q   <= '0;
         rd_data <= '0;
      end else begin
         for (int c = 0; c < NUM_CH; c++) begin
            if (wr_ok && (int'(wr_idx) == c)) mem_q[c] <= wr_data;
         end
         if (rd_en) rd_data <= rd_next;
      end
   end

   // R2
   store_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |=> (mem_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/fcb_flags.sv
module fcb_flags #(
   parameter int NUM_CH = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set_vec,
   input  logic [NUM_CH-1:0] clr_vec,
   input  logic              mask_we,
   input  logic [NUM_CH-1:0] mask_val,
   output logic [NUM_CH-1:0] pend,
   output logic [NUM_CH-1:0] mask
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= '0;
         mask <= '0;
      end else begin
         pend <= (pend & ~clr_vec) | set_vec;
         if (mask_we) mask <= mask_val;
      end
   end

   // R4
   pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((pend & $past(set_vec)) == $past(set_vec)));

   // R5
   pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_vec & ~set_vec) != '0) |=> ((pend & $past(clr_vec & ~set_vec)) == '0));
endmodule

// File: rtl/fcb_irq.sv
module fcb_irq #(
   parameter int               NUM_CH   = 6,
   parameter int               GRP_SIZE = 3,
   parameter fcb_pkg::irq_mode_e IRQ_MODE = fcb_pkg::IRQ_PER_CH,
   localparam int              NUM_GRP  = NUM_CH / GRP_SIZE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CH-1:0]  pend,
   input  logic [NUM_CH-1:0]  mask,
   output logic [NUM_CH-1:0]  irq_ch,
   output logic [NUM_GRP-1:0] irq_grp
);
   logic [NUM_CH-1:0] live;
   assign live = pend & ~mask;

   generate
      if (IRQ_MODE == fcb_pkg::IRQ_PER_CH) begin : g_per_ch
         assign irq_ch  = live;
         assign irq_grp = '0;
      end else begin : g_per_grp
         assign irq_ch = '0;
         for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
            assign irq_grp[g] = |live[g*GRP_SIZE +: GRP_SIZE];
         end
      end
   endgenerate

   // R8
   irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_ch & ~pend) == '0));

   // R10
   irq_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_ch & mask) == '0));
endmodule

// File: rtl/fastchan_bank.sv
module fastchan_bank #(
   parameter int                 NUM_CH   = 6,
   parameter int                 WORD_W   = 32,
   parameter int                 GRP_SIZE = 3,
   parameter fcb_pkg::irq_mode_e IRQ_MODE = fcb_pkg::IRQ_PER_CH,
   localparam int                IDX_W    = fcb_pkg::idx_width(NUM_CH),
   localparam int                NUM_GRP  = NUM_CH / GRP_SIZE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               snd_wr_en,
   input  logic [IDX_W-1:0]   snd_wr_idx,
   input  logic [WORD_W-1:0]  snd_wr_data,
   input  logic               rcv_rd_en,
   input  logic [IDX_W-1:0]   rcv_rd_idx,
   output logic [WORD_W-1:0]  rcv_rd_data,
   input  logic [NUM_CH-1:0]  rcv_clr_vec,
   input  logic               rcv_mask_we,
   input  logic [NUM_CH-1:0]  rcv_mask_val,
   output logic [NUM_CH-1:0]  pend_o,
   output logic [NUM_CH-1:0]  irq_ch,
   output logic [NUM_GRP-1:0] irq_grp,
   output logic [31:0]        cfg_word
);
   localparam int MAX_CH = (WORD_W == 64) ? 512 : 1024;

   generate
      if (WORD_W != 32 && WORD_W != 64) begin : g_bad_width
         $error("fastchan_bank: WORD_W must be 32 or 64");
      end
      if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_count
         $error("fastchan_bank: NUM_CH outside the range allowed for WORD_W");
      end
      if (GRP_SIZE < 1 || (NUM_CH % GRP_SIZE) != 0) begin : g_bad_grp
         $error("fastchan_bank: GRP_SIZE must divide NUM_CH");
      end
   endgenerate

   logic [NUM_CH-1:0] set_vec;
   logic [NUM_CH-1:0] mask;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
         assign set_vec[c] = snd_wr_en && (int'(snd_wr_idx) == c);
      end
   endgenerate

   assign cfg_word = fcb_pkg::make_cfg(NUM_CH, WORD_W);

   fcb_store #(.NUM_CH(NUM_CH), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (snd_wr_en),
      .wr_idx  (snd_wr_idx),
      .wr_data (snd_wr_data),
      .rd_en   (rcv_rd_en),
      .rd_idx  (rcv_rd_idx),
      .rd_data (rcv_rd_data)
   );

   fcb_flags #(.NUM_CH(NUM_CH)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vec  (set_vec),
      .clr_vec  (rcv_clr_vec),
      .mask_we  (rcv_mask_we),
      .mask_val (rcv_mask_val),
      .pend     (pend_o),
      .mask     (mask)
   );

   fcb_irq #(.NUM_CH(NUM_CH), .GRP_SIZE(GRP_SIZE), .IRQ_MODE(IRQ_MODE)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .pend    (pend_o),
      .mask    (mask),
      .irq_ch  (irq_ch),
      .irq_grp (irq_grp)
   );

   // R12
   oob_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_wr_en && (int'(snd_wr_idx) >= NUM_CH) && (rcv_clr_vec == '0)) |=> $stable(pend_o));

   // R6
   write_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_vec & rcv_clr_vec) != '0) |=> ((pend_o & $past(set_vec & rcv_clr_vec)) != '0));
endmodule

// File: tb/fastchan_bank_bench.sv
module fastchan_bank_bench;
   localparam int N   = 6;
   localparam int W   = 32;
   localparam int GS  = 3;
   localparam int NG  = N / GS;
   localparam int IW  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          wr_en = 0;
   logic [IW-1:0] wr_idx = '0;
   logic [W-1:0]  wr_data = '0;
   logic          rd_en = 0;
   logic [IW-1:0] rd_idx = '0;
   logic [N-1:0]  clr = '0;
   logic          mwe = 0;
   logic [N-1:0]  mval = '0;

   logic [W-1:0]  a_rd, b_rd;
   logic [N-1:0]  a_pend, b_pend, a_ich, b_ich;
   logic [NG-1:0] a_igr, b_igr;
   logic [31:0]   a_cfg, b_cfg;

   fastchan_bank u_fastchan_bank (
      .clk(clk), .rst_n(rst_n), .snd_wr_en(wr_en), .snd_wr_idx(wr_idx),
      .snd_wr_data(wr_data), .rcv_rd_en(rd_en), .rcv_rd_idx(rd_idx),
      .rcv_rd_data(a_rd), .rcv_clr_vec(clr), .rcv_mask_we(mwe),
      .rcv_mask_val(mval), .pend_o(a_pend), .irq_ch(a_ich), .irq_grp(a_igr),
      .cfg_word(a_cfg));

   fastchan_bank #(.IRQ_MODE(fcb_pkg::IRQ_PER_GRP)) u_fastchan_bank_grp (
      .clk(clk), .rst_n(rst_n), .snd_wr_en(wr_en), .snd_wr_idx(wr_idx),
      .snd_wr_data(wr_data), .rcv_rd_en(rd_en), .rcv_rd_idx(rd_idx),
      .rcv_rd_data(b_rd), .rcv_clr_vec(clr), .rcv_mask_we(mwe),
      .rcv_mask_val(mval), .pend_o(b_pend), .irq_ch(b_ich), .irq_grp(b_igr),
      .cfg_word(b_cfg));

   int checks = 0;
   int fails  = 0;

   // behavioural reference
   logic [W-1:0] m_data [N];
   logic [N-1:0] m_pend, m_mask;
   logic [W-1:0] m_rd;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) m_data[i] = '0;
         m_pend = '0; m_mask = '0; m_rd = '0;
      end else begin
         if (rd_en) begin
            if (int'(rd_idx) >= N) m_rd = '0;
            else if (wr_en && wr_idx == rd_idx) m_rd = wr_data;
            else m_rd = m_data[rd_idx];
         end
         m_pend = m_pend & ~clr;
         if (wr_en && int'(wr_idx) < N) begin
            m_data[wr_idx] = wr_data;
            m_pend[wr_idx] = 1'b1;
         end
         if (mwe) m_mask = mval;
      end
   end

   function automatic logic [NG-1:0] m_grp(input logic [N-1:0] p, input logic [N-1:0] m);
      logic [NG-1:0] r;
      logic [N-1:0]  live;
      live = p & ~m;
      for (int g = 0; g < NG; g++) begin
         r[g] = 1'b0;
         for (int k = 0; k < GS; k++) r[g] = r[g] | live[g*GS+k];
      end
      return r;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2 rd_data", 64'(a_rd), 64'(m_rd));
         chk("R2 rd_data grp", 64'(b_rd), 64'(m_rd));
         chk("R4 pend", 64'(a_pend), 64'(m_pend));
         chk("R4 pend grp", 64'(b_pend), 64'(m_pend));
         chk("R8 irq_ch", 64'(a_ich), 64'(m_pend & ~m_mask));
         chk("R8 irq_grp zero", 64'(a_igr), 64'(0));
         chk("R9 irq_grp", 64'(b_igr), 64'(m_grp(m_pend, m_mask)));
         chk("R9 irq_ch zero", 64'(b_ich), 64'(0));
      end
   end

   task automatic idle();
      wr_en = 0; rd_en = 0; clr = '0; mwe = 0;
   endtask

   task automatic step();
      @(posedge clk); #1;
      idle();
   endtask

   task automatic do_wr(input int i, input logic [W-1:0] d);
      wr_en = 1; wr_idx = IW'(i); wr_data = d;
   endtask

   task automatic do_rd(input int i);
      rd_en = 1; rd_idx = IW'(i);
   endtask

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 pend", 64'(a_pend), 64'(0));
      chk("R1 irq", 64'({a_ich, b_igr}), 64'(0));
      chk("R1 rd_data", 64'(a_rd), 64'(0));
      // R11 configuration word
      chk("R11 cfg", 64'(a_cfg), 64'h6);
      chk("R11 cfg grp", 64'(b_cfg), 64'h6);
      rst_n = 1;
      step();
      for (int i = 0; i < N; i++) begin
         do_rd(i); step();
         chk("R1 stored word", 64'(a_rd), 64'(0));
      end

      // R2 write then read
      do_wr(2, 32'hA5A5_0001); step();
      do_rd(2); step();
      chk("R2 read latest", 64'(a_rd), 64'h0000_0000_A5A5_0001);

      // R3 overwrite while pending
      do_wr(2, 32'h1234_5678); step();
      chk("R3 pending stays", 64'(a_pend[2]), 64'(1));
      do_rd(2); step();
      chk("R3 new word", 64'(a_rd), 64'h0000_0000_1234_5678);

      // R4 / R5
      do_wr(4, 32'hBEEF); step();
      chk("R4 only ch4 added", 64'(a_pend), 64'h14);
      chk("R9 group 1", 64'(b_igr), 64'h3);
      clr = 6'b000100; step();
      chk("R5 ch2 cleared", 64'(a_pend), 64'h10);

      // R6 write and clear collide
      do_wr(1, 32'h11); clr = 6'b000010; step();
      chk("R6 write beats clear", 64'(a_pend[1]), 64'(1));

      // R7 read and write collide
      do_wr(3, 32'hC0DE_0003); do_rd(3); step();
      chk("R7 bypass read", 64'(a_rd), 64'h0000_0000_C0DE_0003);

      // R10 masking
      mwe = 1; mval = 6'b010000; step();
      chk("R10 masked irq low", 64'(a_ich[4]), 64'(0));
      chk("R10 masked still pending", 64'(a_pend[4]), 64'(1));
      clr = 6'b001000; step();
      chk("R10 group quiet when only masked pend", 64'(b_igr[1]), 64'(0));
      mwe = 1; mval = '0; step();
      chk("R10 unmask raises", 64'(b_igr[1]), 64'(1));

      // R12 out-of-range index
      do_wr(7, 32'hDEAD); step();
      chk("R12 pend unchanged", 64'(a_pend), 64'h12);
      do_rd(7); step();
      chk("R12 oob read zero", 64'(a_rd), 64'(0));

      // random mix
      lfsr = 16'hACE1;
      for (int k = 0; k < 400; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         wr_en   = lfsr[0];
         wr_idx  = lfsr[3:1];
         wr_data = {lfsr, ~lfsr};
         rd_en   = lfsr[4];
         rd_idx  = lfsr[7:5];
         clr     = (lfsr[8]) ? N'(lfsr[14:9]) : '0;
         mwe     = (lfsr[15:13] == 3'b101);
         mval    = N'(lfsr[11:6]);
         step();
      end
      step(); step();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule